// File: doc/BRIEF.md
# Quadrant-Direction Dual-Clock FIFO

This block moves words between two unrelated clock domains through a sixteen-word register array. All sixteen locations hold data. No word is left spare, and the pointers carry no extra wrap bit. When the read and write pointers are equal, the FIFO is either completely full or completely empty. A single direction flag settles which one it is. The flag is updated only from the coarse position of each pointer, meaning which quarter of the array the pointer currently addresses.

Each pointer is a pair of 2-bit Gray counters. The upper pair names the quarter and the lower pair names the slot within that quarter. The lower pair runs in reverse through odd quarters, so the four-bit pointer as a whole changes exactly one bit per step. A copy taken in the other domain is therefore always a value the pointer really held. Each domain keeps its own copy of the direction flag and computes it from its own pointer and a two-flop synchronized copy of the other pointer. Full is raised in the write domain and empty in the read domain. The read port is show-ahead: the oldest word is present on the data output whenever empty is low, and a read request removes it.

Top module: `fifoq_async`

## Requirements
- R1: Sixteen words can be written into an empty FIFO while the reader is idle. full is low before each of the first sixteen writes and rises right after the clock edge that accepts the sixteenth.
- R2: Words leave in the order they were written. When empty is low, rd_data shows the oldest stored word, and an rd_en sampled high at a rising rd_clk edge removes it.
- R3: Data written across pointer wrap-around (more than sixteen words in total, from any starting pointer position) comes out intact.
- R4: The direction flag is set when the read quarter is one step ahead of the write quarter and cleared when it is one step behind. In every other quarter relationship it holds. Equal pointers report full when the flag is set and empty when it is clear, and this works from any pointer offset.
- R5: Pointers cross domains as Gray codes that change one bit per step, through two flops clocked by the receiving side. empty falls on the second rd_clk edge after the writing edge, and full falls on the second wr_clk edge after the reading edge.
- R6: A write while full is high stores nothing and does not move the write pointer. A read while empty is high does not move the read pointer.
- R7: After reset, empty is high and full is low. Each side has its own active-low asynchronous reset.
- R8: Streams in which writes and reads overlap, with the FIFO held near full or near empty, deliver every word once and in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst_n | input | 1 | Write-domain asynchronous reset, active low |
| wr_en | input | 1 | Write request, taken when full is low |
| wr_data | input | DATA_W | Word to store |
| full | output | 1 | All sixteen locations occupied (write domain) |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst_n | input | 1 | Read-domain asynchronous reset, active low |
| rd_en | input | 1 | Read request, taken when empty is low |
| rd_data | output | DATA_W | Oldest stored word (show-ahead) |
| empty | output | 1 | No word stored (read domain) |

## Verification
A write accepted on wr_clk and a read accepted on rd_clk can occur at the same instant while the pointers sit one step from equality. In that case each domain decides full or empty from a stale copy of the other pointer and its own copy of the direction flag. The bench runs the two clocks at unrelated periods and streams with writes and reads interleaved. In one run the reader is slower, so the array stays at or near sixteen words. In another the writer is throttled, so it stays near zero. Every word is judged against the written sequence. Separate tests measure the two-edge flag release latency, and fill-and-drain runs from several pointer offsets confirm that equality is resolved correctly on both sides.

// File: rtl/fifoq_pkg.sv
`timescale 1ns/1ps
package fifoq_pkg;

   localparam int QUAD_W = 2;

   typedef logic [QUAD_W-1:0] quad_t;

   // next quarter in the 2-bit Gray cycle 00 -> 01 -> 11 -> 10 -> 00
   function automatic quad_t quad_fwd(input quad_t g);
      case (g)
         2'b00:   return 2'b01;
         2'b01:   return 2'b11;
         2'b11:   return 2'b10;
         default: return 2'b00;
      endcase
   endfunction

   // previous quarter in the same cycle
   function automatic quad_t quad_rev(input quad_t g);
      case (g)
         2'b00:   return 2'b10;
         2'b10:   return 2'b11;
         2'b11:   return 2'b01;
         default: return 2'b00;
      endcase
   endfunction

endpackage

// File: rtl/fifoq_ptr.sv
`timescale 1ns/1ps
module fifoq_ptr #(
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              inc_req,
   input  logic              hold,
   output logic [ADDR_W-1:0] bin_q,
   output logic [ADDR_W-1:0] gray_q
);

   logic              step;
   logic [ADDR_W-1:0] bin_nxt;

   assign step    = inc_req & ~hold;
   assign bin_nxt = bin_q + 1'b1;

   // upper two Gray bits form the quarter counter, lower bits the slot
   // counter, which runs backwards through odd quarters (reflected code)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bin_q  <= '0;
         gray_q <= '0;
      end else if (step) begin
         bin_q  <= bin_nxt;
         gray_q <= bin_nxt ^ (bin_nxt >> 1);
      end
   end

   // R6: a blocked request leaves the pointer where it was
   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> $stable(gray_q));

   // R5: the crossing value changes in exactly one bit per step
   p_gray_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(gray_q) |-> ($countones(gray_q ^ $past(gray_q)) == 1));

endmodule

// File: rtl/fifoq_sync.sv
`timescale 1ns/1ps
module fifoq_sync #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);

   if (STAGES < 2) begin : g_bad_stages
      $error("fifoq_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
      end else begin
         stage_q[0] <= din;
         for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
      end
   end

   assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/fifoq_dirflag.sv
`timescale 1ns/1ps
module fifoq_dirflag
   import fifoq_pkg::*;
#(
   parameter int ADDR_W    = 4,
   parameter bit IS_WRITER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] own_gray,
   input  logic [ADDR_W-1:0] peer_gray,
   output logic              hit
);

   quad_t own_quad, peer_quad, wr_quad, rd_quad;
   logic  rd_ahead, rd_behind, ptr_same, dir_q;

   assign own_quad  = own_gray[ADDR_W-1 -: QUAD_W];
   assign peer_quad = peer_gray[ADDR_W-1 -: QUAD_W];

   if (IS_WRITER) begin : g_writer
      assign wr_quad = own_quad;
      assign rd_quad = peer_quad;
   end else begin : g_reader
      assign wr_quad = peer_quad;
      assign rd_quad = own_quad;
   end

   // four-input coarse compare: no subtraction of the pointers
   assign rd_ahead  = (rd_quad == quad_fwd(wr_quad));
   assign rd_behind = (rd_quad == quad_rev(wr_quad));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         dir_q <= 1'b0;
      else if (rd_ahead)  dir_q <= 1'b1;
      else if (rd_behind) dir_q <= 1'b0;
   end

   assign ptr_same = (own_gray == peer_gray);

   if (IS_WRITER) begin : g_full
      assign hit = ptr_same & dir_q;
   end else begin : g_empty
      assign hit = ptr_same & ~dir_q;
   end

   // R4: same quarter or opposite quarters leave the flag untouched
   p_dir_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((rd_quad == wr_quad) || (rd_quad == quad_fwd(quad_fwd(wr_quad))))
      |=> $stable(dir_q));

endmodule

// File: rtl/fifoq_mem.sv
`timescale 1ns/1ps
module fifoq_mem #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16,
   localparam int ADDR_W = $clog2(DEPTH)
) (
   input  logic              wr_clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] cell_q [DEPTH];

   always_ff @(posedge wr_clk) begin
      if (we) cell_q[waddr] <= wdata;
   end

   assign rdata = cell_q[raddr];

endmodule

// File: rtl/fifoq_async.sv
`timescale 1ns/1ps
module fifoq_async #(
   parameter int DATA_W      = 8,
   parameter int DEPTH       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              wr_clk,
   input  logic              wr_rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic              full,
   input  logic              rd_clk,
   input  logic              rd_rst_n,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              empty
);

   localparam int ADDR_W = $clog2(DEPTH);

   if (DEPTH != 16) begin : g_bad_depth
      $error("fifoq_async: the quarter scheme is built for DEPTH = 16");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("fifoq_async: DATA_W must be positive");
   end

   logic [ADDR_W-1:0] wbin, wgray, rbin, rgray;
   logic [ADDR_W-1:0] rgray_w, wgray_r;
   logic              wr_take;

   assign wr_take = wr_en & ~full;

   // ---------------- write domain ----------------
   fifoq_ptr #(.ADDR_W(ADDR_W)) u_wptr (
      .clk    (wr_clk),
      .rst_n  (wr_rst_n),
      .inc_req(wr_en),
      .hold   (full),
      .bin_q  (wbin),
      .gray_q (wgray)
   );

   fifoq_sync #(.W(ADDR_W), .STAGES(SYNC_STAGES)) u_r2w (
      .clk  (wr_clk),
      .rst_n(wr_rst_n),
      .din  (rgray),
      .dout (rgray_w)
   );

   fifoq_dirflag #(.ADDR_W(ADDR_W), .IS_WRITER(1'b1)) u_wflag (
      .clk      (wr_clk),
      .rst_n    (wr_rst_n),
      .own_gray (wgray),
      .peer_gray(rgray_w),
      .hit      (full)
   );

   // ---------------- read domain ----------------
   fifoq_ptr #(.ADDR_W(ADDR_W)) u_rptr (
      .clk    (rd_clk),
      .rst_n  (rd_rst_n),
      .inc_req(rd_en),
      .hold   (empty),
      .bin_q  (rbin),
      .gray_q (rgray)
   );

   fifoq_sync #(.W(ADDR_W), .STAGES(SYNC_STAGES)) u_w2r (
      .clk  (rd_clk),
      .rst_n(rd_rst_n),
      .din  (wgray),
      .dout (wgray_r)
   );

   fifoq_dirflag #(.ADDR_W(ADDR_W), .IS_WRITER(1'b0)) u_rflag (
      .clk      (rd_clk),
      .rst_n    (rd_rst_n),
      .own_gray (rgray),
      .peer_gray(wgray_r),
      .hit      (empty)
   );

   // ---------------- storage ----------------
   fifoq_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
      .wr_clk(wr_clk),
      .we    (wr_take),
      .waddr (wbin),
      .wdata (wr_data),
      .raddr (rbin),
      .rdata (rd_data)
   );

   // R1: full only ever stands on equal pointers
   p_full_eq_r1: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
      full |-> (wgray == rgray_w));

   // R4: empty only ever stands on equal pointers
   p_empty_eq_r4: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      empty |-> (rgray == wgray_r));

   // R7: the first write-domain edge after reset sees an unfilled FIFO
   p_reset_state_r7: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
      $rose(wr_rst_n) |-> !full);

endmodule

// File: tb/sim_fifoq_async.sv
`timescale 1ns/1ps
module sim_fifoq_async;

   localparam int DW = 8;

   logic          wr_clk = 1'b0, rd_clk = 1'b0;
   logic          wr_rst_n = 1'b0, rd_rst_n = 1'b0;
   logic          wr_en = 1'b0, rd_en = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic [DW-1:0] rd_data;
   logic          full, empty;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 wr_clk = ~wr_clk;   // 200 MHz write side
   always #3.6 rd_clk = ~rd_clk;   // unrelated read side

   fifoq_async #(.DATA_W(DW), .DEPTH(16), .SYNC_STAGES(2)) u0 (
      .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .full(full),
      .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en(rd_en), .rd_data(rd_data),
      .empty(empty)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic push(input logic [DW-1:0] d);
      @(negedge wr_clk);
      wr_en   = 1'b1;
      wr_data = d;
      @(negedge wr_clk);
      wr_en   = 1'b0;
   endtask

   task automatic pop(output logic [DW-1:0] d);
      @(negedge rd_clk);
      d     = rd_data;
      rd_en = 1'b1;
      @(negedge rd_clk);
      rd_en = 1'b0;
   endtask

   task automatic settle();
      repeat (6) @(negedge wr_clk);
      repeat (6) @(negedge rd_clk);
   endtask

   // R7: reset state
   task automatic t_reset();
      wr_rst_n = 1'b0;
      rd_rst_n = 1'b0;
      #20.3;
      wr_rst_n = 1'b1;
      rd_rst_n = 1'b1;
      settle();
      chk("R7 empty after reset", empty, 1);
      chk("R7 full after reset", full, 0);
   endtask

   // R1 R2 R3 R4 R6: fill and drain starting from a given pointer offset
   task automatic t_fill_drain(input int offset, input logic [DW-1:0] base);
      logic [DW-1:0] got;
      for (int i = 0; i < offset; i++) begin
         push(8'h90 + i[7:0]);
         settle();
         pop(got);
         chk("R3 offset word", got, 8'h90 + i[7:0]);
      end
      settle();
      for (int i = 0; i < 16; i++) begin
         @(negedge wr_clk);
         chk("R1 full low before write", full, 0);
         push(base + i[7:0]);
      end
      chk("R1 R4 full after sixteenth write", full, 1);
      push(8'hEE);                       // R6: must be dropped
      chk("R6 full holds after refused write", full, 1);
      settle();
      chk("R4 not empty when full", empty, 0);
      for (int i = 0; i < 16; i++) begin
         @(negedge rd_clk);
         chk("R4 empty low while draining", empty, 0);
         pop(got);
         chk("R2 drain order", got, base + i[7:0]);
      end
      chk("R4 R6 empty after sixteenth read", empty, 1);
      pop(got);                          // R6: read while empty
      settle();
      chk("R4 full low after drain", full, 0);
      push(8'h5A);
      settle();
      chk("R6 word visible after refused read", rd_data, 8'h5A);
      chk("R6 empty low with one word", empty, 0);
      pop(got);
      chk("R6 empty after last pop", empty, 1);
      settle();
   endtask

   // R5: two-edge release latency in both directions
   task automatic t_latency();
      logic [DW-1:0] got;
      @(negedge wr_clk);
      wr_en   = 1'b1;
      wr_data = 8'hC3;
      @(posedge wr_clk);
      fork begin #1 wr_en = 1'b0; end join_none
      @(posedge rd_clk); #0.3;
      chk("R5 empty held one read edge", empty, 1);
      @(posedge rd_clk); #0.3;
      chk("R5 empty released on second read edge", empty, 0);
      chk("R5 data present", rd_data, 8'hC3);
      pop(got);
      settle();
      for (int i = 0; i < 16; i++) push(8'h40 + i[7:0]);
      settle();
      chk("R5 full before read", full, 1);
      @(negedge rd_clk);
      rd_en = 1'b1;
      @(posedge rd_clk);
      fork begin #1 rd_en = 1'b0; end join_none
      @(posedge wr_clk); #0.3;
      chk("R5 full held one write edge", full, 1);
      @(posedge wr_clk); #0.3;
      chk("R5 full released on second write edge", full, 0);
      settle();
      for (int i = 1; i < 16; i++) begin
         pop(got);
         chk("R5 remaining order", got, 8'h40 + i[7:0]);
      end
      chk("R5 empty after cleanup", empty, 1);
      settle();
   endtask

   // R8 R3: overlapping streams; gap throttles the writer
   task automatic t_stream(input int n, input int gap, input logic [DW-1:0] seed);
      fork
         begin : w_side
            int k    = 0;
            int idle = 0;
            while (k < n) begin
               @(negedge wr_clk);
               if (!full && idle == 0) begin
                  wr_en   = 1'b1;
                  wr_data = seed + k[7:0];
                  k++;
                  idle = gap;
               end else begin
                  wr_en = 1'b0;
                  if (idle > 0) idle--;
               end
            end
            @(negedge wr_clk);
            wr_en = 1'b0;
         end
         begin : r_side
            int m = 0;
            logic [DW-1:0] e;
            while (m < n) begin
               @(negedge rd_clk);
               if (!empty) begin
                  e = seed + m[7:0];
                  chk("R8 stream order", rd_data, e);
                  rd_en = 1'b1;
                  m++;
               end else begin
                  rd_en = 1'b0;
               end
            end
            @(negedge rd_clk);
            rd_en = 1'b0;
         end
      join
      settle();
      chk("R8 empty after stream", empty, 1);
      chk("R8 full low after stream", full, 0);
   endtask

   initial begin
      t_reset();
      t_fill_drain(0, 8'h00);
      t_fill_drain(1, 8'h20);
      t_fill_drain(3, 8'h30);
      t_fill_drain(6, 8'h60);
      t_fill_drain(11, 8'hA0);
      t_latency();
      t_stream(60, 0, 8'h10);   // reader slower: sits near full
      t_stream(40, 3, 8'h80);   // writer throttled: sits near empty
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #500000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule